// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a port of already synchronized GPIO pin values and turns selected pin activity into interrupt requests. Each pin is configured independently. It can sense a level, high or low, or an edge, rising or falling. It can also fire on both edges, and that setting takes precedence over the polarity choice. Edge events are latched in a sticky status bit until software clears it. Level conditions are reported as they stand, with no latching.

Software reaches the block over a simple register bus. The bus is one pin-wide data word per access, selected by a three-bit register index. Through it, software reads the raw per-pin status and the masked status, which is the raw status gated by the enables. It clears latched edge events by writing ones. A single interrupt output is high while any masked status bit is set.

Top module: `gpio_irq_detect`

## Requirements
- R1: After synchronous reset, all configuration, enable and latched edge registers read zero, and `irq` is low.
- R2: For a pin with its sense bit (index 0) at 1, the raw status bit (index 4) equals 1 exactly while the pin equals its polarity bit (index 2), where 1 means high and 0 means low. It follows the pin in the same cycle.
- R3: For a pin with its sense bit at 0 and its both-edges bit (index 1) at 0, a rising edge sets the latched status bit when the polarity bit is 1. A falling edge sets it when the polarity bit is 0.
- R4: For an edge-sensed pin with its both-edges bit at 1, either edge sets the latched status bit, whatever the polarity bit holds.
- R5: The masked status (index 5) equals raw status AND the enable register (index 3). `irq` is high exactly while the masked status is nonzero.
- R6: A write to the clear index (6) clears each latched edge bit whose data bit is 1. Bits written as 0 keep their value.
- R7: A clear write has no effect on the raw status of level-sensed pins.
- R8: An edge detected in the same cycle as a clear of that bit leaves the bit set.
- R9: Writes to the raw, masked, clear and unused indices (4 to 7) change no register. Reads of indices 6 and 7 return zero.
- R10: An edge is detected by comparing the pin with its value on the previous clock edge. The latched bit becomes visible one clock after the edge edge that samples the new pin value. The pin's sampled value is zero at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Synchronized pin values |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt, high while any masked bit is set |

## Verification
Two functions can fall in the same clock edge: edge capture on a pin and a software clear aimed at that same latched bit. The bench provokes this directly by toggling a pin in the cycle where it writes ones to the clear index. It also provokes it at random, with clear writes mixed among random pin traffic. In every case the bit must read set afterwards. Each cycle's expected state comes from a bench model that updates sticky bits as (old AND NOT clear) OR new-edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_SENSE  = 3'd0,
        REG_BOTH   = 3'd1,
        REG_POL    = 3'd2,
        REG_EN     = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASKED = 3'd5,
        REG_CLEAR  = 3'd6,
        REG_SPARE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edge_kind_e;

    function automatic edge_kind_e classify(input logic now, input logic prev);
        if (now && !prev)      return EV_RISE;
        else if (!now && prev) return EV_FALL;
        else                   return EV_NONE;
    endfunction

    function automatic logic edge_fires(input edge_kind_e ev, input logic pol, input logic both);
        if (ev == EV_NONE) return 1'b0;
        if (both)          return 1'b1;
        return pol ? (ev == EV_RISE) : (ev == EV_FALL);
    endfunction

    function automatic logic level_true(input logic pin, input logic pol);
        return pin == pol;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  sense,
    output logic [NPINS-1:0]  both,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  en,
    output logic [NPINS-1:0]  clr_vec
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense <= '0;
            both  <= '0;
            pol   <= '0;
            en    <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_SENSE: sense <= wdata;
                REG_BOTH:  both  <= wdata;
                REG_POL:   pol   <= wdata;
                REG_EN:    en    <= wdata;
                default:   ;
            endcase
        end
    end

    assign clr_vec = (wr_en && sel == REG_CLEAR) ? wdata : '0;

    // R9: status/clear/spare indices never reach the configuration storage
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= 3'd4) |=> ($stable(sense) && $stable(both) && $stable(pol) && $stable(en)));

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] sense,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] lvl
);
    logic [NPINS-1:0] pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_in;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        edge_kind_e ev;
        assign ev     = classify(pin_in[i], pin_q[i]);
        assign hit[i] = !sense[i] && edge_fires(ev, pol[i], both[i]);
        assign lvl[i] = sense[i] && level_true(pin_in[i], pol[i]);
    end

    // R10: an unchanged pin never yields an edge event
    a_r10_no_change_no_hit: assert property (@(posedge clk) disable iff (rst)
        ((hit & ~(pin_in ^ pin_q)) == '0));

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] sense,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] masked,
    output logic             irq
);
    logic [NPINS-1:0] edge_st;

    always_ff @(posedge clk) begin
        if (rst) edge_st <= '0;
        else     edge_st <= (edge_st & ~clr_vec & ~sense) | hit;
    end

    assign raw    = (sense & lvl) | (~sense & edge_st);
    assign masked = raw & en;
    assign irq    = |masked;

    // R8: a detected edge always lands, even against a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((edge_st & $past(hit)) == $past(hit)));

    // R6: cleared bits without a new edge are gone next cycle
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec & ~hit) != '0) |=> ((edge_st & $past(clr_vec & ~hit)) == '0));

    // R3: a latched bit only appears after a detected edge
    a_r3_set_needs_hit: assert property (@(posedge clk) disable iff (rst)
        ((edge_st & ~$past(edge_st) & ~$past(hit)) == '0));

    // R5: interrupt line agrees with raw status and enables
    a_r5_irq_agrees: assert property (@(posedge clk) disable iff (rst)
        irq == ((raw & en) != '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    output logic              irq
);
    logic [NPINS-1:0] sense, both, pol, en, clr_vec;
    logic [NPINS-1:0] hit, lvl, raw, masked;

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sense(sense), .both(both), .pol(pol), .en(en), .clr_vec(clr_vec)
    );

    gpio_irq_sense #(.NPINS(NPINS)) u_sense (
        .clk(clk), .rst(rst), .pin_in(pin_in), .sense(sense), .both(both),
        .pol(pol), .hit(hit), .lvl(lvl)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_status (
        .clk(clk), .rst(rst), .hit(hit), .lvl(lvl), .sense(sense), .en(en),
        .clr_vec(clr_vec), .raw(raw), .masked(masked), .irq(irq)
    );

    always_comb begin
        case (reg_sel_e'(addr))
            REG_SENSE:  rdata = sense;
            REG_BOTH:   rdata = both;
            REG_POL:    rdata = pol;
            REG_EN:     rdata = en;
            REG_RAW:    rdata = raw;
            REG_MASKED: rdata = masked;
            default:    rdata = '0;
        endcase
    end

    // R1: one cycle out of reset nothing is pending
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (en == '0));

endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] m_sense = '0, m_both = '0, m_pol = '0, m_en = '0;
    logic [N-1:0] m_edge = '0, m_pq = '0;

    always #4 clk = ~clk;

    gpio_irq_detect #(.NPINS(N)) u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [N-1:0] mdl_raw(input logic [N-1:0] p);
        return (m_sense & ~(p ^ m_pol)) | (~m_sense & m_edge);
    endfunction

    function automatic logic [N-1:0] mdl_hit(input logic [N-1:0] p);
        logic [N-1:0] rise, fall;
        rise = p & ~m_pq;
        fall = ~p & m_pq;
        return ~m_sense & ((m_both & (rise | fall)) |
                           (~m_both & m_pol & rise) |
                           (~m_both & ~m_pol & fall));
    endfunction

    function automatic logic [N-1:0] mdl_read(input logic [2:0] a, input logic [N-1:0] p);
        case (a)
            3'd0: return m_sense;
            3'd1: return m_both;
            3'd2: return m_pol;
            3'd3: return m_en;
            3'd4: return mdl_raw(p);
            3'd5: return mdl_raw(p) & m_en;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic w, input logic [2:0] a,
                        input logic [N-1:0] d, input logic [N-1:0] p);
        logic [N-1:0] h, clr;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; pin_in = p;
        #1;
        if (!w) check(tag, rdata, mdl_read(a, p));
        check(tag, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, ((mdl_raw(p) & m_en) != '0)});
        @(posedge clk);
        h   = mdl_hit(p);
        clr = (w && a == 3'd6) ? d : '0;
        m_edge = (m_edge & ~clr & ~m_sense) | h;
        m_pq = p;
        if (w) begin
            case (a)
                3'd0: m_sense = d;
                3'd1: m_both  = d;
                3'd2: m_pol   = d;
                3'd3: m_en    = d;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [N-1:0] p);
        step(tag, 1'b0, a, '0, p);
    endtask

    task automatic wr(input string tag, input logic [2:0] a, input logic [N-1:0] d, input logic [N-1:0] p);
        step(tag, 1'b1, a, d, p);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] p;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        for (int a = 0; a < 8; a++) rd("R1", 3'(a), '0);

        // R2: level sensing, both polarities, live following
        wr("R2", 3'd0, 8'h03, '0);
        wr("R2", 3'd2, 8'h01, '0);
        rd("R2", 3'd4, 8'h00);
        rd("R2", 3'd4, 8'h01);
        rd("R2", 3'd4, 8'h03);
        rd("R2", 3'd4, 8'h02);
        wr("R2", 3'd0, 8'h00, 8'h00);

        // R3: single edges by polarity, R10 one-cycle latency
        wr("R3", 3'd2, 8'h04, 8'h00);
        rd("R3", 3'd4, 8'h0C);
        rd("R10", 3'd4, 8'h0C);
        rd("R3", 3'd4, 8'h00);
        rd("R3", 3'd4, 8'h00);
        wr("R6", 3'd6, 8'hFF, 8'h00);

        // R4: both edges override polarity
        wr("R4", 3'd1, 8'h30, 8'h00);
        wr("R4", 3'd2, 8'h10, 8'h00);
        rd("R4", 3'd4, 8'h30);
        rd("R4", 3'd4, 8'h30);
        wr("R4", 3'd6, 8'h30, 8'h30);
        rd("R4", 3'd4, 8'h00);
        rd("R4", 3'd4, 8'h00);

        // R5: masked view and interrupt line
        wr("R5", 3'd3, 8'h20, 8'h00);
        rd("R5", 3'd5, 8'h00);
        rd("R5", 3'd5, 8'h00);
        wr("R5", 3'd3, 8'h00, 8'h00);
        rd("R5", 3'd5, 8'h00);

        // R6: partial clear leaves zero-written bits
        wr("R6", 3'd6, 8'h10, 8'h00);
        rd("R6", 3'd4, 8'h00);

        // R7: clear has no effect on a level-sensed pin
        wr("R7", 3'd0, 8'h80, 8'h00);
        wr("R7", 3'd2, 8'h80, 8'h80);
        wr("R7", 3'd6, 8'hFF, 8'h80);
        rd("R7", 3'd4, 8'h80);
        wr("R7", 3'd0, 8'h00, 8'h00);

        // R8: edge in the same cycle as its clear
        wr("R8", 3'd6, 8'hFF, 8'h00);
        rd("R8", 3'd4, 8'h00);
        wr("R8", 3'd6, 8'hFF, 8'h30);
        rd("R8", 3'd4, 8'h30);

        // R9: writes to read-only and spare indices
        for (int a = 4; a < 8; a++) wr("R9", 3'(a), 8'hFF, 8'h30);
        for (int a = 0; a < 8; a++) rd("R9", 3'(a), 8'h30);

        // R10: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] a;
            p = 8'($urandom);
            if (($urandom % 4) == 0) p = m_pq ^ (8'h1 << ($urandom % 8));
            a = 3'($urandom % 8);
            if (($urandom % 3) == 0) wr("R10", a, 8'($urandom), p);
            else                     rd("R10", a, p);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule